// File: doc/BRIEF.md
# Serially Read Bus Capture Buffer

This block stores captured bus transactions for a transaction monitor and lets a debug host read them over a test-access port. On the system clock side, the monitor presents a 50-bit capture word with a one-cycle valid strobe. The block writes each word into a 512-slot store. Upstream logic packs the word, from MSB to LSB, as: a trigger-hit flag, a write/read flag (1 for write), fourteen word-address bits, two zero bits and thirty-two data bits. The block stores the word as it is given.

On the TCK side, the host selects one of four data registers with a 2-bit instruction code. It then uses capture-DR, shift-DR and update-DR strobes to move bits between tdi and tdo. Through these registers the host can:
- read the number of stored entries and a sticky overflow flag,
- pop the oldest entry,
- clear the buffer.

A full read-out first queries the count, then issues the pop instruction that many times, then queries the count again. The write and read pointers cross between the two clocks as Gray code.

Top module: `jtag_capture_fifo`

## Requirements
- R1: After both resets are applied, the count register reads 0 with the overflow flag clear, and a pop returns all zeros.
- R2: Instruction codes select the data register: 0 is a 1-bit bypass, 1 is the 10-bit status register (bits [8:0] hold the entry count, bit 9 the overflow flag), 2 is the 32-bit clear register, and 3 is the 50-bit entry register. Each register loads on a TCK edge with captureDr high. It then shifts right on each TCK edge with shiftDr high: tdo always shows bit 0, and tdi enters at the register's top bit.
- R3: Entries come out oldest first, one per pop (captureDr with code 3). Each pop moves the read pointer by exactly one.
- R4: The status count equals the number of entries written minus the number popped or cleared, once the pointer crossing has settled (two TCK edges).
- R5: The store holds at most 511 entries. A valid strobe while full drops the word and sets the overflow flag, which stays set.
- R6: A pop while empty loads all zeros and leaves the read pointer unchanged, so the next stored word is the next one popped.
- R7: An update-DR under code 2 whose 32-bit register holds all zeros empties the buffer and clears the overflow flag. The buffer is emptied by advancing the read pointer one step per TCK edge until it meets the write pointer. Any non-zero value in the register leaves the buffer untouched.
- R8: Under code 0, tdo repeats tdi one shift later, and the captured bit is 0.
- R9: Each registered pointer that crosses clock domains changes at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock for the capture side |
| sysRstN | input | 1 | Active-low asynchronous reset, system side |
| capValid | input | 1 | One-cycle strobe: store capWord |
| capWord | input | 50 | Capture word to store |
| tck | input | 1 | Test clock for the host side |
| tckRstN | input | 1 | Active-low asynchronous reset, TCK side |
| tdi | input | 1 | Serial data in |
| irCode | input | 2 | Selected instruction code |
| captureDr | input | 1 | Capture-DR strobe |
| shiftDr | input | 1 | Shift-DR strobe |
| updateDr | input | 1 | Update-DR strobe |
| tdo | output | 1 | Serial data out |

## Verification
The assertions assume the TAP sequencer never raises captureDr and shiftDr in the same cycle. They also assume irCode stays stable from capture through update. The bench drives every access as one capture edge, a run of shift edges and one update edge, with the code held throughout. It changes inputs and samples tdo only while tck is low. Between system-side writes and host queries, it waits several TCK edges so that the synchronised pointers have settled before a count is taken.

// File: rtl/capfifo_pkg.sv
package capfifo_pkg;

  typedef enum logic [1:0] {
    IR_BYPASS = 2'd0,
    IR_COUNT  = 2'd1,
    IR_CLEAR  = 2'd2,
    IR_READ   = 2'd3
  } irSel_e;

  // strobes from the TCK-side control to the datapath
  typedef struct packed {
    irSel_e sel;
    logic   capture;
    logic   shift;
    logic   pop;
    logic   advance;
    logic   startClear;
  } tckCtl_t;

endpackage

// File: rtl/capfifo_gray_sync.sv
module capfifo_gray_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] grayIn,
  output logic [W-1:0] binOut
);
  logic [W-1:0] meta;
  logic [W-1:0] sync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta <= '0;
      sync <= '0;
    end else begin
      meta <= grayIn;
      sync <= meta;
    end
  end

  // gray to binary: bit i is the parity of all gray bits at or above i
  always_comb begin
    for (int i = 0; i < W; i++) binOut[i] = ^(sync >> i);
  end
endmodule

// File: rtl/capfifo_ctrl.sv
module capfifo_ctrl
  import capfifo_pkg::*;
(
  input  logic       tck,
  input  logic       tckRstN,
  input  logic [1:0] irCode,
  input  logic       captureDr,
  input  logic       shiftDr,
  input  logic       updateDr,
  input  logic       isEmpty,
  input  logic       clearWordZero,
  output tckCtl_t    ctl
);
  irSel_e irSel;
  logic   draining;

  assign irSel = irSel_e'(irCode);

  always_comb begin
    ctl.sel        = irSel;
    ctl.capture    = captureDr;
    ctl.shift      = shiftDr && !captureDr;
    ctl.startClear = updateDr && (irSel == IR_CLEAR) && clearWordZero;
    ctl.pop        = captureDr && (irSel == IR_READ) && !isEmpty && !draining;
    ctl.advance    = ctl.pop || (draining && !isEmpty);
  end

  // clearing walks the read pointer up to the write pointer one step a cycle
  always_ff @(posedge tck or negedge tckRstN) begin
    if (!tckRstN)            draining <= 1'b0;
    else if (ctl.startClear) draining <= 1'b1;
    else if (isEmpty)        draining <= 1'b0;
  end

  assert_drain_progress_R7: assert property (@(posedge tck) disable iff (!tckRstN)
    (draining && !isEmpty && !ctl.startClear) |=> (draining || isEmpty));
endmodule

// File: rtl/capfifo_store.sv
module capfifo_store
  import capfifo_pkg::*;
#(
  parameter int DATA_W  = 50,
  parameter int ADDR_W  = 9,
  parameter int CLEAR_W = 32
) (
  input  logic              sysClk,
  input  logic              sysRstN,
  input  logic              capValid,
  input  logic [DATA_W-1:0] capWord,
  input  logic              tck,
  input  logic              tckRstN,
  input  logic              tdi,
  input  tckCtl_t           ctl,
  output logic              isEmpty,
  output logic              clearWordZero,
  output logic              tdo
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int POS_W = $clog2(DATA_W);

  logic [DATA_W-1:0] mem [DEPTH];

  // ---------------- system clock side ----------------
  logic [ADDR_W-1:0] wrPtr, wrPtrInc, wrGray, rdSyncBin;
  logic              isFull, overflow, clrPulse;
  logic [2:0]        clrSync;
  logic              clrToggle;

  assign wrPtrInc = wrPtr + 1'b1;
  assign isFull   = (wrPtrInc == rdSyncBin);
  assign clrPulse = clrSync[2] ^ clrSync[1];

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      wrPtr    <= '0;
      wrGray   <= '0;
      overflow <= 1'b0;
      clrSync  <= '0;
    end else begin
      clrSync <= {clrSync[1:0], clrToggle};
      if (capValid && !isFull) begin
        wrPtr  <= wrPtrInc;
        wrGray <= wrPtrInc ^ (wrPtrInc >> 1);
      end
      if (capValid && isFull) overflow <= 1'b1;
      else if (clrPulse)      overflow <= 1'b0;
    end
  end

  always_ff @(posedge sysClk) begin
    if (capValid && !isFull) mem[wrPtr] <= capWord;
  end

  // ---------------- TCK side ----------------
  logic [ADDR_W-1:0] rdPtr, rdPtrInc, rdGray, wrSyncBin, entryCount;
  logic              ovfMeta, ovfTck;
  logic [DATA_W-1:0] drShift, shiftNext, loadWord;
  logic [POS_W-1:0]  insertPos;

  assign rdPtrInc   = rdPtr + 1'b1;
  assign entryCount = wrSyncBin - rdPtr;
  assign isEmpty    = (entryCount == '0);

  always_ff @(posedge tck or negedge tckRstN) begin
    if (!tckRstN) begin
      rdPtr     <= '0;
      rdGray    <= '0;
      clrToggle <= 1'b0;
      ovfMeta   <= 1'b0;
      ovfTck    <= 1'b0;
    end else begin
      ovfMeta <= overflow;
      ovfTck  <= ovfMeta;
      if (ctl.startClear) clrToggle <= !clrToggle;
      if (ctl.advance) begin
        rdPtr  <= rdPtrInc;
        rdGray <= rdPtrInc ^ (rdPtrInc >> 1);
      end
    end
  end

  capfifo_gray_sync #(.W(ADDR_W)) u_rdSync (
    .clk(sysClk), .rstN(sysRstN), .grayIn(rdGray), .binOut(rdSyncBin));
  capfifo_gray_sync #(.W(ADDR_W)) u_wrSync (
    .clk(tck), .rstN(tckRstN), .grayIn(wrGray), .binOut(wrSyncBin));

  always_comb begin
    unique case (ctl.sel)
      IR_COUNT: insertPos = POS_W'(ADDR_W);
      IR_CLEAR: insertPos = POS_W'(CLEAR_W - 1);
      IR_READ:  insertPos = POS_W'(DATA_W - 1);
      default:  insertPos = '0;
    endcase
    shiftNext            = drShift >> 1;
    shiftNext[insertPos] = tdi;

    loadWord = '0;
    if (ctl.sel == IR_COUNT) loadWord[ADDR_W:0] = {ovfTck, entryCount};
    else if (ctl.pop)        loadWord = mem[rdPtr];
  end

  always_ff @(posedge tck or negedge tckRstN) begin
    if (!tckRstN)         drShift <= '0;
    else if (ctl.capture) drShift <= loadWord;
    else if (ctl.shift)   drShift <= shiftNext;
  end

  assign clearWordZero = (drShift[CLEAR_W-1:0] == '0);
  assign tdo           = drShift[0];

  // ---------------- assertions ----------------
  assert_wr_gray_step_R9: assert property (@(posedge sysClk) disable iff (!sysRstN)
    $countones(wrGray ^ $past(wrGray)) <= 1);
  assert_rd_gray_step_R9: assert property (@(posedge tck) disable iff (!tckRstN)
    $countones(rdGray ^ $past(rdGray)) <= 1);
  assert_full_drops_R5: assert property (@(posedge sysClk) disable iff (!sysRstN)
    (capValid && isFull) |=> (overflow && $stable(wrGray)));
  assert_empty_pop_still_R6: assert property (@(posedge tck) disable iff (!tckRstN)
    (ctl.capture && ctl.sel == IR_READ && isEmpty) |=> $stable(rdGray));
  assert_pop_step_R3: assert property (@(posedge tck) disable iff (!tckRstN)
    ctl.pop |=> (rdPtr == ADDR_W'($past(rdPtr) + 1'b1)));
  assert_bypass_delay_R8: assert property (@(posedge tck) disable iff (!tckRstN)
    (ctl.shift && ctl.sel == IR_BYPASS) |=> (tdo == $past(tdi)));
endmodule

// File: rtl/jtag_capture_fifo.sv
module jtag_capture_fifo
  import capfifo_pkg::*;
#(
  parameter int DATA_W  = 50,
  parameter int ADDR_W  = 9,
  parameter int CLEAR_W = 32
) (
  input  logic              sysClk,
  input  logic              sysRstN,
  input  logic              capValid,
  input  logic [DATA_W-1:0] capWord,
  input  logic              tck,
  input  logic              tckRstN,
  input  logic              tdi,
  input  logic [1:0]        irCode,
  input  logic              captureDr,
  input  logic              shiftDr,
  input  logic              updateDr,
  output logic              tdo
);
  tckCtl_t ctl;
  logic    isEmpty;
  logic    clearWordZero;

  capfifo_ctrl u_ctrl (
    .tck(tck), .tckRstN(tckRstN), .irCode(irCode),
    .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr),
    .isEmpty(isEmpty), .clearWordZero(clearWordZero), .ctl(ctl));

  capfifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CLEAR_W(CLEAR_W)) u_store (
    .sysClk(sysClk), .sysRstN(sysRstN), .capValid(capValid), .capWord(capWord),
    .tck(tck), .tckRstN(tckRstN), .tdi(tdi), .ctl(ctl),
    .isEmpty(isEmpty), .clearWordZero(clearWordZero), .tdo(tdo));

  assert_strobes_exclusive_R2: assert property (@(posedge tck) disable iff (!tckRstN)
    !(captureDr && shiftDr));
endmodule

// File: tb/tb_jtag_capture_fifo.sv
module tb_jtag_capture_fifo;
  logic        sysClk = 0, sysRstN = 0, capValid = 0;
  logic [49:0] capWord = '0;
  logic        tck = 0, tckRstN = 0, tdi = 0;
  logic [1:0]  irCode = 0;
  logic        captureDr = 0, shiftDr = 0, updateDr = 0;
  logic        tdo;
  int          total = 0, bad = 0;

  jtag_capture_fifo dut (.*);

  always #4 sysClk = ~sysClk;   // 125 MHz

  localparam logic [49:0] VEC [6] = '{
    50'h0_0000_0000_0001, 50'h3_FFFF_FFFF_FFFF, 50'h1_2340_DEAD_BEEF,
    50'h2_8001_8000_0001, 50'h0_5554_AAAA_5555, 50'h3_0000_0000_0000 };

  task automatic checkEq(string req, logic [49:0] act, logic [49:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tckCycle();
    #10 tck = 1;
    #10 tck = 0;
  endtask

  task automatic idleTck(int n);
    for (int i = 0; i < n; i++) tckCycle();
  endtask

  task automatic jtagShift(input logic [1:0] code, input int len,
                           input logic [49:0] din, output logic [49:0] dout);
    dout = '0;
    irCode = code; captureDr = 1;
    tckCycle();
    captureDr = 0; shiftDr = 1;
    for (int i = 0; i < len; i++) begin
      dout[i] = tdo;
      tdi = din[i];
      tckCycle();
    end
    shiftDr = 0; updateDr = 1;
    tckCycle();
    updateDr = 0; tdi = 0;
  endtask

  task automatic pushWord(logic [49:0] w);
    @(negedge sysClk);
    capValid = 1; capWord = w;
    @(negedge sysClk);
    capValid = 0;
  endtask

  task automatic readStatus(output logic [8:0] cnt, output logic ovf);
    logic [49:0] d;
    jtagShift(2'd1, 10, '0, d);
    cnt = d[8:0]; ovf = d[9];
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [49:0] d;
    logic [8:0]  cnt;
    logic        ovf;
    idleTck(2);
    #7 sysRstN = 1; tckRstN = 1;
    idleTck(2);

    // R1: reset state
    readStatus(cnt, ovf);
    checkEq("R1 count", 50'(cnt), 50'd0);
    checkEq("R1 ovf", 50'(ovf), 50'd0);
    jtagShift(2'd3, 50, '0, d);
    checkEq("R1 pop zeros", d, '0);

    // R8: bypass delays by one, captured bit 0
    jtagShift(2'd0, 8, 50'hB5, d);
    checkEq("R8 bypass", d & 50'hFF, 50'h6A);

    // R3/R4: table walk, oldest first, LSB first (R2 shift order)
    for (int i = 0; i < 6; i++) pushWord(VEC[i]);
    idleTck(4);
    readStatus(cnt, ovf);
    checkEq("R4 count six", 50'(cnt), 50'd6);
    for (int i = 0; i < 6; i++) begin
      jtagShift(2'd3, 50, '0, d);
      checkEq("R3 pop order", d, VEC[i]);
      if (i == 2) begin
        readStatus(cnt, ovf);
        checkEq("R4 count three", 50'(cnt), 50'd3);
      end
    end
    readStatus(cnt, ovf);
    checkEq("R4 count drained", 50'(cnt), 50'd0);

    // R6: empty pop gives zeros and keeps pointer
    jtagShift(2'd3, 50, '0, d);
    checkEq("R6 empty zeros", d, '0);
    pushWord(50'h1_ABCD_1234_5678);
    idleTck(4);
    jtagShift(2'd3, 50, '0, d);
    checkEq("R6 next word", d, 50'h1_ABCD_1234_5678);

    // R7: non-zero clear word ignored, zero word empties
    for (int i = 0; i < 3; i++) pushWord(VEC[i]);
    idleTck(4);
    jtagShift(2'd2, 32, 50'h1, d);
    idleTck(8);
    readStatus(cnt, ovf);
    checkEq("R7 nonzero kept", 50'(cnt), 50'd3);
    jtagShift(2'd2, 32, '0, d);
    idleTck(8);
    readStatus(cnt, ovf);
    checkEq("R7 cleared", 50'(cnt), 50'd0);
    pushWord(VEC[4]);
    idleTck(4);
    jtagShift(2'd3, 50, '0, d);
    checkEq("R7 after clear", d, VEC[4]);

    // R5/R9: fill past capacity across the clock crossing
    for (int i = 0; i < 512; i++) pushWord(50'(i));
    idleTck(4);
    readStatus(cnt, ovf);
    checkEq("R5 R9 full count", 50'(cnt), 50'd511);
    checkEq("R5 ovf set", 50'(ovf), 50'd1);
    jtagShift(2'd3, 50, '0, d);
    checkEq("R5 oldest kept", d, 50'd0);
    readStatus(cnt, ovf);
    checkEq("R4 after pop", 50'(cnt), 50'd510);
    checkEq("R5 ovf sticky", 50'(ovf), 50'd1);
    jtagShift(2'd2, 32, '0, d);
    idleTck(560);
    readStatus(cnt, ovf);
    checkEq("R7 big clear", 50'(cnt), 50'd0);
    checkEq("R7 ovf cleared", 50'(ovf), 50'd0);

    summary();
    $finish;
  end
endmodule